// File: doc/BRIEF.md
# Trap Entry Controller

This block sits next to a processor's control-status state and decides, every clock, whether the core must leave its current instruction stream. It samples level-sensitive interrupt lines into a pending field, masks them with a local enable field, and admits an interrupt only when global interrupt enable is set and the core is outside debug state. Synchronous exceptions, bus errors and debug breakpoints come in as single-cycle requests that carry the faulting PC. The block then picks one entry path and issues a one-cycle redirect strobe with the handler address.

There are three entry paths, and each saves state into its own registers. The ordinary path covers exceptions, bus errors and interrupts. It saves the previous mode, the return address and the cause, and it vectors from the entry base by cause times the spacing field. The TLB-refill path saves into refill-only registers, forces direct-address mode, and jumps to the refill base with no per-cause offset. The debug path saves the return address, sets the debug-state flag, and jumps to a fixed offset above the entry base. A small write port loads the mode and configuration fields.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, privilege level is 0, global enable 0, direct-address mode 1, paging 0, local-enable mask 0, vector spacing 0, debug flag 0, redirect strobe 0 and redirect PC 0x1C000000.
- R2: One cycle after a change on the interrupt lines, each line's level is visible in its own bit of the pending field. The hard-interrupt request is high exactly when some pending bit is 1.
- R3: An interrupt entry happens only when the global enable is 1, the debug flag is 0 and the pending field ANDed with the local-enable mask is nonzero. Otherwise no strobe is produced.
- R4: On an interrupt, the highest enabled pending index i wins. The handler PC is entry base + (64 + i) × spacing, and the cause field is written with 0.
- R5: A synchronous exception with code c sets handler PC = entry base + c × spacing. It writes c to the cause field, copies the privilege level and enable into the previous-mode fields, and stores the faulting PC as the return address.
- R6: Every non-debug entry forces privilege level 0 and global enable 0. The redirect strobe lasts one cycle per entry.
- R7: An exception flagged as TLB refill saves the privilege level and enable into the refill previous-mode fields and the PC into the refill return address. It sets direct-address 1 and paging 0, and jumps to the refill base. The ordinary cause, return address and previous-mode fields are left unchanged.
- R8: A breakpoint with the debug flag clear stores the PC as the debug return address, sets the debug flag and jumps to entry base + 0x480. Privilege level and enable are left unchanged.
- R9: A breakpoint with the debug flag already set only sets the sticky nested-debug indicator. It produces no strobe and leaves the debug return address unchanged.
- R10: A bus error on instruction fetch is taken as an ordinary exception with code 8. A bus error on a data access is taken with code 9.
- R11: When several requests arrive in one cycle, priority runs breakpoint, then bus error, then synchronous exception, then interrupt.
- R12: A write-port cycle loads privilege level, enable, direct-address, paging, local-enable mask and spacing, visible one cycle later. An entry in the same cycle overrides the privilege and enable it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt lines |
| csr_wr_en | input | 1 | Load the mode/config fields below |
| csr_wr_plv | input | 2 | New privilege level |
| csr_wr_ie | input | 1 | New global interrupt enable |
| csr_wr_da | input | 1 | New direct-address mode bit |
| csr_wr_pg | input | 1 | New paging bit |
| csr_wr_lie | input | NUM_IRQ | New local-enable mask |
| csr_wr_vs | input | VS_W | New vector spacing |
| eentry_base | input | PC_W | Ordinary and debug entry base |
| refill_base | input | PC_W | TLB-refill entry base |
| cur_pc | input | PC_W | PC of the current instruction |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Cause code of the exception |
| exc_refill | input | 1 | The exception is a TLB refill |
| bus_err_valid | input | 1 | Bus error request |
| bus_err_fetch | input | 1 | Bus error was on instruction fetch |
| brk_valid | input | 1 | Debug breakpoint request |
| redirect_valid | output | 1 | One-cycle entry strobe |
| redirect_pc | output | PC_W | Handler address |
| hard_irq_req | output | 1 | Some pending bit is set |
| irq_pending | output | NUM_IRQ | Pending field |
| lie_mask | output | NUM_IRQ | Local-enable mask |
| vec_space | output | VS_W | Vector spacing |
| mode_plv | output | 2 | Current privilege level |
| mode_ie | output | 1 | Global interrupt enable |
| mode_da | output | 1 | Direct-address mode |
| mode_pg | output | 1 | Paging mode |
| prev_plv | output | 2 | Saved privilege level (ordinary) |
| prev_ie | output | 1 | Saved enable (ordinary) |
| exc_ra | output | PC_W | Ordinary return address |
| exc_cause | output | CODE_W | Cause field |
| rf_prev_plv | output | 2 | Saved privilege level (refill) |
| rf_prev_ie | output | 1 | Saved enable (refill) |
| rf_ra | output | PC_W | Refill return address |
| dbg_ra | output | PC_W | Debug return address |
| dbg_active | output | 1 | Debug-state flag |
| dbg_nested | output | 1 | Sticky nested-breakpoint indicator |

## Verification
Exception, bus-error, breakpoint and write-port results are due one edge after the request, because the entry decision and all saved state are registered together. An interrupt needs two edges: the first captures the lines into the pending field, and the second takes the entry. The bench drives every input on the falling edge and samples on the next falling edge after the edge where the result is due. For interrupts it first confirms that pending and the request are visible while the strobe is still low, and one cycle later it checks the redirect. Cases where nothing should happen are watched over several cycles to confirm that the strobe stays low.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_DEBUG  = 3'd1,
    EV_NESTED = 3'd2,
    EV_EXC    = 3'd3,
    EV_REFILL = 3'd4,
    EV_IRQ    = 3'd5
  } entry_kind_e;

  localparam int CAUSE_INT        = 0;
  localparam int CAUSE_FETCH_ADDR = 8;
  localparam int CAUSE_MEM_ADDR   = 9;

  // Highest set bit of a 32-bit word; 0 when the word is empty.
  function automatic int unsigned top_index(input logic [31:0] word);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (word[i]) r = i;
    end
    return r;
  endfunction

  // Offset of a vectored handler from its base.
  function automatic logic [31:0] vec_offset(input logic [31:0] code,
                                             input logic [31:0] spacing);
    return code * spacing;
  endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_IRQ = 13,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] lines,
  input  logic [NUM_IRQ-1:0] lie,
  output logic [NUM_IRQ-1:0] pending,
  output logic               any_pend,
  output logic               any_en,
  output logic [IDX_W-1:0]   win_idx
);
  import trap_entry_pkg::*;

  logic [NUM_IRQ-1:0] masked;
  logic [31:0]        masked32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= lines;
  end

  assign masked   = pending & lie;
  assign masked32 = 32'(masked);
  assign any_pend = |pending;
  assign any_en   = |masked;
  assign win_idx  = IDX_W'(top_index(masked32));

  p_winner_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> (pending[win_idx] && lie[win_idx]));

  p_request_tracks_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (any_pend == (|$past(lines))));

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int PC_W     = 32,
  parameter int CODE_W   = 7,
  parameter int VS_W     = 3,
  parameter int IDX_W    = 4,
  parameter int EXT_BASE = 64,
  parameter int DBG_OFF  = 'h480
) (
  input  logic                        brk_valid,
  input  logic                        bus_err_valid,
  input  logic                        bus_err_fetch,
  input  logic                        exc_valid,
  input  logic [CODE_W-1:0]           exc_code,
  input  logic                        exc_refill,
  input  logic                        ie,
  input  logic                        dbg,
  input  logic                        any_en,
  input  logic [IDX_W-1:0]            win_idx,
  input  logic [VS_W-1:0]             vs,
  input  logic [PC_W-1:0]             eentry_base,
  input  logic [PC_W-1:0]             refill_base,
  output trap_entry_pkg::entry_kind_e kind,
  output logic [CODE_W-1:0]           code,
  output logic [PC_W-1:0]             target
);
  import trap_entry_pkg::*;

  logic [31:0] irq_code;
  logic [31:0] berr_code;

  assign irq_code  = 32'(EXT_BASE) + 32'(win_idx);
  assign berr_code = bus_err_fetch ? 32'(CAUSE_FETCH_ADDR) : 32'(CAUSE_MEM_ADDR);

  always_comb begin
    kind   = EV_NONE;
    code   = '0;
    target = eentry_base;
    if (brk_valid) begin
      kind   = dbg ? EV_NESTED : EV_DEBUG;
      target = eentry_base + PC_W'(DBG_OFF);
    end else if (bus_err_valid) begin
      kind   = EV_EXC;
      code   = CODE_W'(berr_code);
      target = eentry_base + PC_W'(vec_offset(berr_code, 32'(vs)));
    end else if (exc_valid) begin
      code = exc_code;
      if (exc_refill) begin
        kind   = EV_REFILL;
        target = refill_base;
      end else begin
        kind   = EV_EXC;
        target = eentry_base + PC_W'(vec_offset(32'(exc_code), 32'(vs)));
      end
    end else if (ie && !dbg && any_en) begin
      kind   = EV_IRQ;
      code   = CODE_W'(CAUSE_INT);
      target = eentry_base + PC_W'(vec_offset(irq_code, 32'(vs)));
    end
  end

endmodule

// File: rtl/mode_state.sv
module mode_state #(
  parameter int              PC_W     = 32,
  parameter int              CODE_W   = 7,
  parameter int              VS_W     = 3,
  parameter int              NUM_IRQ  = 13,
  parameter logic [PC_W-1:0] RESET_PC = 32'h1C00_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  trap_entry_pkg::entry_kind_e kind,
  input  logic [CODE_W-1:0]           code,
  input  logic [PC_W-1:0]             target,
  input  logic [PC_W-1:0]             cur_pc,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_plv,
  input  logic                        wr_ie,
  input  logic                        wr_da,
  input  logic                        wr_pg,
  input  logic [NUM_IRQ-1:0]          wr_lie,
  input  logic [VS_W-1:0]             wr_vs,
  output logic                        redirect_valid,
  output logic [PC_W-1:0]             redirect_pc,
  output logic [1:0]                  plv,
  output logic                        ie,
  output logic                        da,
  output logic                        pg,
  output logic [NUM_IRQ-1:0]          lie,
  output logic [VS_W-1:0]             vs,
  output logic [1:0]                  pplv,
  output logic                        pie,
  output logic [PC_W-1:0]             era,
  output logic [CODE_W-1:0]           ecode,
  output logic [1:0]                  rf_pplv,
  output logic                        rf_pie,
  output logic [PC_W-1:0]             rf_era,
  output logic [PC_W-1:0]             dera,
  output logic                        dbg,
  output logic                        nested
);
  import trap_entry_pkg::*;

  logic ord_entry;
  logic rf_entry;
  logic dbg_entry;
  logic any_entry;

  assign ord_entry = (kind == EV_EXC) || (kind == EV_IRQ);
  assign rf_entry  = (kind == EV_REFILL);
  assign dbg_entry = (kind == EV_DEBUG);
  assign any_entry = ord_entry || rf_entry || dbg_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= RESET_PC;
      plv     <= '0;
      ie      <= 1'b0;
      da      <= 1'b1;
      pg      <= 1'b0;
      lie     <= '0;
      vs      <= '0;
      pplv    <= '0;
      pie     <= 1'b0;
      era     <= '0;
      ecode   <= '0;
      rf_pplv <= '0;
      rf_pie  <= 1'b0;
      rf_era  <= '0;
      dera    <= '0;
      dbg     <= 1'b0;
      nested  <= 1'b0;
    end else begin
      redirect_valid <= any_entry;
      if (any_entry) redirect_pc <= target;
      if (wr_en) begin
        plv <= wr_plv;
        ie  <= wr_ie;
        da  <= wr_da;
        pg  <= wr_pg;
        lie <= wr_lie;
        vs  <= wr_vs;
      end
      if (ord_entry) begin
        pplv  <= plv;
        pie   <= ie;
        era   <= cur_pc;
        ecode <= code;
      end
      if (rf_entry) begin
        rf_pplv <= plv;
        rf_pie  <= ie;
        rf_era  <= cur_pc;
        da      <= 1'b1;
        pg      <= 1'b0;
      end
      if (ord_entry || rf_entry) begin
        plv <= '0;
        ie  <= 1'b0;
      end
      if (dbg_entry) begin
        dera <= cur_pc;
        dbg  <= 1'b1;
      end
      if (kind == EV_NESTED) nested <= 1'b1;
    end
  end

  p_entry_drops_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_entry || rf_entry) |=> (plv == 2'd0 && !ie && redirect_valid));

  p_refill_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_entry |=> (da && !pg && $stable(ecode)));

  p_debug_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg |=> dbg);

  p_nested_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_NESTED) |=> (!redirect_valid && nested && $stable(dera)));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int              PC_W     = 32,
  parameter int              CODE_W   = 7,
  parameter int              VS_W     = 3,
  parameter int              NUM_IRQ  = 13,
  parameter int              EXT_BASE = 64,
  parameter int              DBG_OFF  = 'h480,
  parameter logic [PC_W-1:0] RESET_PC = 32'h1C00_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               csr_wr_en,
  input  logic [1:0]         csr_wr_plv,
  input  logic               csr_wr_ie,
  input  logic               csr_wr_da,
  input  logic               csr_wr_pg,
  input  logic [NUM_IRQ-1:0] csr_wr_lie,
  input  logic [VS_W-1:0]    csr_wr_vs,
  input  logic [PC_W-1:0]    eentry_base,
  input  logic [PC_W-1:0]    refill_base,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               exc_valid,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic               exc_refill,
  input  logic               bus_err_valid,
  input  logic               bus_err_fetch,
  input  logic               brk_valid,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               hard_irq_req,
  output logic [NUM_IRQ-1:0] irq_pending,
  output logic [NUM_IRQ-1:0] lie_mask,
  output logic [VS_W-1:0]    vec_space,
  output logic [1:0]         mode_plv,
  output logic               mode_ie,
  output logic               mode_da,
  output logic               mode_pg,
  output logic [1:0]         prev_plv,
  output logic               prev_ie,
  output logic [PC_W-1:0]    exc_ra,
  output logic [CODE_W-1:0]  exc_cause,
  output logic [1:0]         rf_prev_plv,
  output logic               rf_prev_ie,
  output logic [PC_W-1:0]    rf_ra,
  output logic [PC_W-1:0]    dbg_ra,
  output logic               dbg_active,
  output logic               dbg_nested
);
  import trap_entry_pkg::*;

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic              any_en;
  logic [IDX_W-1:0]  win_idx;
  entry_kind_e       kind;
  logic [CODE_W-1:0] code;
  logic [PC_W-1:0]   target;
  logic              irq_fire;

  irq_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .lie      (lie_mask),
    .pending  (irq_pending),
    .any_pend (hard_irq_req),
    .any_en   (any_en),
    .win_idx  (win_idx)
  );

  trap_arbiter #(
    .PC_W(PC_W), .CODE_W(CODE_W), .VS_W(VS_W), .IDX_W(IDX_W),
    .EXT_BASE(EXT_BASE), .DBG_OFF(DBG_OFF)
  ) u_arb (
    .brk_valid     (brk_valid),
    .bus_err_valid (bus_err_valid),
    .bus_err_fetch (bus_err_fetch),
    .exc_valid     (exc_valid),
    .exc_code      (exc_code),
    .exc_refill    (exc_refill),
    .ie            (mode_ie),
    .dbg           (dbg_active),
    .any_en        (any_en),
    .win_idx       (win_idx),
    .vs            (vec_space),
    .eentry_base   (eentry_base),
    .refill_base   (refill_base),
    .kind          (kind),
    .code          (code),
    .target        (target)
  );

  mode_state #(
    .PC_W(PC_W), .CODE_W(CODE_W), .VS_W(VS_W), .NUM_IRQ(NUM_IRQ),
    .RESET_PC(RESET_PC)
  ) u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .kind           (kind),
    .code           (code),
    .target         (target),
    .cur_pc         (cur_pc),
    .wr_en          (csr_wr_en),
    .wr_plv         (csr_wr_plv),
    .wr_ie          (csr_wr_ie),
    .wr_da          (csr_wr_da),
    .wr_pg          (csr_wr_pg),
    .wr_lie         (csr_wr_lie),
    .wr_vs          (csr_wr_vs),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .plv            (mode_plv),
    .ie             (mode_ie),
    .da             (mode_da),
    .pg             (mode_pg),
    .lie            (lie_mask),
    .vs             (vec_space),
    .pplv           (prev_plv),
    .pie            (prev_ie),
    .era            (exc_ra),
    .ecode          (exc_cause),
    .rf_pplv        (rf_prev_plv),
    .rf_pie         (rf_prev_ie),
    .rf_era         (rf_ra),
    .dera           (dbg_ra),
    .dbg            (dbg_active),
    .nested         (dbg_nested)
  );

  assign irq_fire = (kind == EV_IRQ);

  p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |-> (mode_ie && !dbg_active && ((irq_pending & lie_mask) != '0)));

  p_sync_over_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || bus_err_valid || brk_valid) |-> !irq_fire);

endmodule

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
  localparam int PC_W = 32;
  localparam int CODE_W = 7;
  localparam int VS_W = 3;
  localparam int NUM_IRQ = 13;
  localparam logic [31:0] EBASE = 32'h0000_2000;
  localparam logic [31:0] RBASE = 32'h0000_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IRQ-1:0] irq_lines = '0;
  logic csr_wr_en = 0;
  logic [1:0] csr_wr_plv = 0;
  logic csr_wr_ie = 0, csr_wr_da = 0, csr_wr_pg = 0;
  logic [NUM_IRQ-1:0] csr_wr_lie = '0;
  logic [VS_W-1:0] csr_wr_vs = '0;
  logic [PC_W-1:0] cur_pc = '0;
  logic exc_valid = 0, exc_refill = 0, bus_err_valid = 0, bus_err_fetch = 0, brk_valid = 0;
  logic [CODE_W-1:0] exc_code = '0;

  logic redirect_valid, hard_irq_req, mode_ie, mode_da, mode_pg, prev_ie;
  logic rf_prev_ie, dbg_active, dbg_nested;
  logic [PC_W-1:0] redirect_pc, exc_ra, rf_ra, dbg_ra;
  logic [NUM_IRQ-1:0] irq_pending, lie_mask;
  logic [VS_W-1:0] vec_space;
  logic [1:0] mode_plv, prev_plv, rf_prev_plv;
  logic [CODE_W-1:0] exc_cause;

  int checks = 0;
  int errors = 0;
  logic [CODE_W-1:0] last_cause;

  always #5 clk = ~clk;

  trap_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .csr_wr_en(csr_wr_en), .csr_wr_plv(csr_wr_plv), .csr_wr_ie(csr_wr_ie),
    .csr_wr_da(csr_wr_da), .csr_wr_pg(csr_wr_pg), .csr_wr_lie(csr_wr_lie),
    .csr_wr_vs(csr_wr_vs), .eentry_base(EBASE), .refill_base(RBASE),
    .cur_pc(cur_pc), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_refill(exc_refill), .bus_err_valid(bus_err_valid),
    .bus_err_fetch(bus_err_fetch), .brk_valid(brk_valid),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .hard_irq_req(hard_irq_req), .irq_pending(irq_pending),
    .lie_mask(lie_mask), .vec_space(vec_space), .mode_plv(mode_plv),
    .mode_ie(mode_ie), .mode_da(mode_da), .mode_pg(mode_pg),
    .prev_plv(prev_plv), .prev_ie(prev_ie), .exc_ra(exc_ra),
    .exc_cause(exc_cause), .rf_prev_plv(rf_prev_plv), .rf_prev_ie(rf_prev_ie),
    .rf_ra(rf_ra), .dbg_ra(dbg_ra), .dbg_active(dbg_active),
    .dbg_nested(dbg_nested)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_csr(input logic [1:0] plv, input logic ie, input logic da,
                        input logic pg, input logic [NUM_IRQ-1:0] lie,
                        input logic [VS_W-1:0] vs);
    csr_wr_en = 1; csr_wr_plv = plv; csr_wr_ie = ie; csr_wr_da = da;
    csr_wr_pg = pg; csr_wr_lie = lie; csr_wr_vs = vs;
    step();
    csr_wr_en = 0;
  endtask

  task automatic t_reset();
    chk("R1", "plv", 32'(mode_plv), 0);
    chk("R1", "ie", 32'(mode_ie), 0);
    chk("R1", "da", 32'(mode_da), 1);
    chk("R1", "pg", 32'(mode_pg), 0);
    chk("R1", "lie", 32'(lie_mask), 0);
    chk("R1", "vs", 32'(vec_space), 0);
    chk("R1", "dbg", 32'(dbg_active), 0);
    chk("R1", "strobe", 32'(redirect_valid), 0);
    chk("R1", "pc", redirect_pc, 32'h1C00_0000);
  endtask

  task automatic t_pending();
    irq_lines = 13'h0005;
    step();
    chk("R2", "pending", 32'(irq_pending), 32'h5);
    chk("R2", "request", 32'(hard_irq_req), 1);
    step();
    chk("R3", "no strobe with ie=0", 32'(redirect_valid), 0);
    irq_lines = '0;
    step();
    chk("R2", "pending cleared", 32'(irq_pending), 0);
    chk("R2", "request dropped", 32'(hard_irq_req), 0);
  endtask

  task automatic t_csr_write();
    wr_csr(2'd3, 1'b1, 1'b0, 1'b1, 13'h0100, 3'd4);
    chk("R12", "plv", 32'(mode_plv), 3);
    chk("R12", "ie", 32'(mode_ie), 1);
    chk("R12", "da", 32'(mode_da), 0);
    chk("R12", "pg", 32'(mode_pg), 1);
    chk("R12", "lie", 32'(lie_mask), 32'h100);
    chk("R12", "vs", 32'(vec_space), 4);
  endtask

  task automatic t_masked();
    int seen = 0;
    irq_lines = 13'h0003;
    for (int i = 0; i < 4; i++) begin
      step();
      if (redirect_valid) seen++;
    end
    chk("R3", "masked lines take no entry", 32'(seen), 0);
    chk("R3", "ie still set", 32'(mode_ie), 1);
    irq_lines = '0;
    step();
  endtask

  task automatic t_irq(input logic [NUM_IRQ-1:0] lie, input logic [NUM_IRQ-1:0] lines,
                       input int win, input logic [31:0] pc);
    wr_csr(2'd3, 1'b1, 1'b0, 1'b1, lie, 3'd4);
    cur_pc = pc;
    irq_lines = lines;
    step();
    chk("R4", "no entry while lines are latched", 32'(redirect_valid), 0);
    step();
    chk("R4", "strobe", 32'(redirect_valid), 1);
    chk("R4", "handler pc", redirect_pc, EBASE + 32'((64 + win) * 4));
    chk("R4", "cause", 32'(exc_cause), 0);
    chk("R5", "prev plv", 32'(prev_plv), 3);
    chk("R5", "prev ie", 32'(prev_ie), 1);
    chk("R5", "return addr", exc_ra, pc);
    chk("R6", "plv forced", 32'(mode_plv), 0);
    chk("R6", "ie cleared", 32'(mode_ie), 0);
    step();
    chk("R6", "strobe one cycle", 32'(redirect_valid), 0);
    irq_lines = '0;
    step();
    last_cause = 0;
  endtask

  task automatic t_sync_exc();
    wr_csr(2'd2, 1'b1, 1'b0, 1'b1, 13'h1FFF, 3'd4);
    cur_pc = 32'h0000_4440;
    exc_valid = 1; exc_code = 7'd13;
    step();
    exc_valid = 0;
    chk("R5", "strobe", 32'(redirect_valid), 1);
    chk("R5", "handler pc", redirect_pc, EBASE + 32'(13 * 4));
    chk("R5", "cause", 32'(exc_cause), 13);
    chk("R5", "prev plv", 32'(prev_plv), 2);
    chk("R5", "prev ie", 32'(prev_ie), 1);
    chk("R5", "return addr", exc_ra, 32'h0000_4440);
    chk("R6", "plv forced", 32'(mode_plv), 0);
    chk("R6", "ie cleared", 32'(mode_ie), 0);
    last_cause = 13;
  endtask

  task automatic t_bus_err(input logic fetch);
    wr_csr(2'd1, 1'b0, 1'b0, 1'b1, 13'h0, 3'd2);
    cur_pc = 32'h0000_5000;
    bus_err_valid = 1; bus_err_fetch = fetch;
    step();
    bus_err_valid = 0;
    chk("R10", "strobe", 32'(redirect_valid), 1);
    chk("R10", "cause", 32'(exc_cause), fetch ? 8 : 9);
    chk("R10", "handler pc", redirect_pc, EBASE + (fetch ? 32'd16 : 32'd18));
    last_cause = fetch ? 7'd8 : 7'd9;
  endtask

  task automatic t_refill();
    wr_csr(2'd1, 1'b1, 1'b0, 1'b1, 13'h0, 3'd4);
    cur_pc = 32'h0000_6660;
    exc_valid = 1; exc_code = 7'd5; exc_refill = 1;
    step();
    exc_valid = 0; exc_refill = 0;
    chk("R7", "strobe", 32'(redirect_valid), 1);
    chk("R7", "handler pc", redirect_pc, RBASE);
    chk("R7", "rf prev plv", 32'(rf_prev_plv), 1);
    chk("R7", "rf prev ie", 32'(rf_prev_ie), 1);
    chk("R7", "rf return", rf_ra, 32'h0000_6660);
    chk("R7", "da", 32'(mode_da), 1);
    chk("R7", "pg", 32'(mode_pg), 0);
    chk("R7", "cause kept", 32'(exc_cause), 32'(last_cause));
    chk("R7", "ordinary return kept", exc_ra, 32'h0000_5000);
    chk("R6", "plv forced", 32'(mode_plv), 0);
  endtask

  task automatic t_simultaneous();
    wr_csr(2'd0, 1'b1, 1'b1, 1'b0, 13'h1FFF, 3'd1);
    cur_pc = 32'h0000_7000;
    bus_err_valid = 1; bus_err_fetch = 0;
    exc_valid = 1; exc_code = 7'd20;
    step();
    bus_err_valid = 0; exc_valid = 0;
    chk("R11", "bus error over exception", 32'(exc_cause), 9);
    wr_csr(2'd0, 1'b1, 1'b1, 1'b0, 13'h1FFF, 3'd1);
    irq_lines = 13'h0800;
    step();
    exc_valid = 1; exc_code = 7'd21;
    step();
    exc_valid = 0;
    chk("R11", "exception over interrupt", 32'(exc_cause), 21);
    chk("R11", "exception pc", redirect_pc, EBASE + 32'd21);
    step();
    chk("R11", "interrupt dropped after ie cleared", 32'(redirect_valid), 0);
    irq_lines = '0;
    step();
  endtask

  task automatic t_debug();
    wr_csr(2'd3, 1'b1, 1'b1, 1'b0, 13'h1FFF, 3'd4);
    cur_pc = 32'h0000_8888;
    brk_valid = 1; exc_valid = 1; exc_code = 7'd3;
    step();
    brk_valid = 0; exc_valid = 0;
    chk("R11", "breakpoint over exception cause", 32'(exc_cause), 21);
    chk("R8", "strobe", 32'(redirect_valid), 1);
    chk("R8", "handler pc", redirect_pc, EBASE + 32'h480);
    chk("R8", "debug return", dbg_ra, 32'h0000_8888);
    chk("R8", "debug flag", 32'(dbg_active), 1);
    chk("R8", "plv kept", 32'(mode_plv), 3);
    chk("R8", "ie kept", 32'(mode_ie), 1);
    irq_lines = 13'h0010;
    step();
    step();
    chk("R3", "no interrupt in debug state", 32'(redirect_valid), 0);
    step();
    chk("R3", "still none", 32'(redirect_valid), 0);
    irq_lines = '0;
    cur_pc = 32'h0000_9990;
    brk_valid = 1;
    step();
    brk_valid = 0;
    chk("R9", "no strobe", 32'(redirect_valid), 0);
    chk("R9", "nested set", 32'(dbg_nested), 1);
    chk("R9", "debug return kept", dbg_ra, 32'h0000_8888);
    chk("R9", "plv kept", 32'(mode_plv), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_csr_write();
    t_masked();
    t_irq(13'h1FFF, 13'h1012, 12, 32'h0000_3000);
    t_irq(13'h0FFF, 13'h1012, 4, 32'h0000_3100);
    t_sync_exc();
    t_bus_err(1'b1);
    t_bus_err(1'b0);
    t_refill();
    t_simultaneous();
    t_debug();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule